// File: doc/BRIEF.md
# DRAM Address Width Detector

This block works out at start-up how many multiplexed row/column address bits an attached DRAM module responds to. It does so by trial. For each candidate width it asks an external pattern tester to exercise one location: the last cell of a square array whose row and column are both that wide. The widest candidate goes first, and the search stops at the first candidate the tester reports as good.

Each trial is a request/response exchange. The detector raises a request carrying the candidate width, the test address and the address mask. The tester accepts the request with a ready strobe. Later it returns one response pulse with a pass/fail bit. When the search ends, the detector latches the chosen width and presents the matching column mask and memory size (one unit per column cell). If every candidate fails, it raises a failure flag. A one-cycle start pulse launches or relaunches a search at any time the block is idle.

Top module: `addr_width_detect`

## Requirements
- R1: After reset, busy, done, detect_fail and trial_valid are 0, det_width and det_mask are 0, and mem_size is 1.
- R2: A start pulse while idle sets busy in the next cycle and issues a first trial with width MAX_BITS (12), address (1<<24)-1 and mask (1<<12)-1.
- R3: While trial_valid is high and trial_ready is low, trial_valid stays high and trial_width, trial_addr and trial_mask hold their values.
- R4: A failing response to a trial of width n, with n greater than MIN_BITS+1, issues the next trial at width n-1 with address (1<<2(n-1))-1 and mask (1<<(n-1))-1.
- R5: A passing response ends the search. In the next cycle done is high for exactly one cycle, busy is low, detect_fail is 0, and det_width is the width that passed.
- R6: det_mask equals (1<<det_width)-1 and mem_size equals 1<<det_width at all times.
- R7: If the trials at widths 12, 11, 10 and 9 all fail, the search ends after exactly those four trials with detect_fail set, det_width 8, det_mask 0xFF and mem_size 256.
- R8: A start pulse while busy is ignored. The running search keeps its sequence of trial widths, and no new search begins once it ends.
- R9: res_valid is ignored unless a trial has been accepted and its response is pending. It changes neither the trial nor busy nor the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a search (honoured only while idle) |
| trial_valid | output | 1 | A trial request is offered |
| trial_ready | input | 1 | Tester accepts the offered trial |
| trial_width | output | 4 | Candidate width of the offered trial |
| trial_addr | output | 24 | Linear address to test, (1<<2n)-1 |
| trial_mask | output | 12 | Row/column mask of the candidate, (1<<n)-1 |
| res_valid | input | 1 | Tester response strobe |
| res_pass | input | 1 | Response verdict, 1 = location works |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when a search ends |
| detect_fail | output | 1 | Last search found no working width |
| det_width | output | 4 | Latched detected width |
| det_mask | output | 12 | Mask of the latched width |
| mem_size | output | 13 | 1 << det_width |

## Verification
The bench sweeps a modelled module depth from 6 to 14 bits, and the modelled tester passes any trial no wider than that depth. Depths of 12 and above show that the first trial stops the search. Depths 9 to 11 show that each failure steps down by exactly one bit. Depths of 8 and below drive the all-fail path and its flag. Each depth is repeated with an accept and response latency of zero, one and two cycles, which tests whether requests hold steady while stalled. On the slowest runs, stray start and response strobes are injected while busy to show that they change neither the trial order nor the final result.

// File: rtl/adw_pkg.sv
package adw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } adw_state_e;
endpackage

// File: rtl/adw_geom.sv
// Derives mask, corner address and size from a width, one bit per slice.
module adw_geom #(
  parameter int MAX_BITS = 12,
  parameter int WW       = 4
) (
  input  logic [WW-1:0]         width,
  output logic [MAX_BITS-1:0]   mask,
  output logic [2*MAX_BITS-1:0] addr,
  output logic [MAX_BITS:0]     size
);
  for (genvar i = 0; i < MAX_BITS; i++) begin : g_mask
    assign mask[i] = (32'(width) > i);
  end
  for (genvar j = 0; j < 2*MAX_BITS; j++) begin : g_addr
    assign addr[j] = (2*32'(width) > j);
  end
  for (genvar k = 0; k <= MAX_BITS; k++) begin : g_size
    assign size[k] = (32'(width) == k);
  end
endmodule

// File: rtl/adw_cand.sv
// Candidate width register: loads the widest geometry, steps down on fail.
module adw_cand #(
  parameter int MAX_BITS = 12,
  parameter int WW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          dec,
  output logic [WW-1:0] cand
);
  localparam logic [WW-1:0] MAX_W = WW'(MAX_BITS);

  logic [WW-1:0] cand_d, cand_q;
  logic          cand_en;

  always_comb begin
    cand_en = load | dec;
    cand_d  = cand_q;
    if (load)     cand_d = MAX_W;
    else if (dec) cand_d = cand_q - WW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cand_q <= MAX_W;
    else if (cand_en) cand_q <= cand_d;
  end

  assign cand = cand_q;
endmodule

// File: rtl/adw_ctrl.sv
// Search sequencer: issue trial, await verdict, step or finish.
module adw_ctrl
  import adw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic trial_ready,
  input  logic res_valid,
  input  logic res_pass,
  input  logic cand_last,
  output logic load,
  output logic dec,
  output logic latch_pass,
  output logic latch_fail,
  output logic trial_valid,
  output logic busy,
  output logic in_wait,
  output logic done
);
  adw_state_e state_d, state_q;
  logic       done_d, done_q;

  always_comb begin
    state_d    = state_q;
    load       = 1'b0;
    dec        = 1'b0;
    latch_pass = 1'b0;
    latch_fail = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load    = 1'b1;
          state_d = ST_ISSUE;
        end
      end
      ST_ISSUE: begin
        if (trial_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (res_valid) begin
          if (res_pass) begin
            latch_pass = 1'b1;
            state_d    = ST_IDLE;
          end else if (!cand_last) begin
            dec     = 1'b1;
            state_d = ST_ISSUE;
          end else begin
            dec        = 1'b1;
            latch_fail = 1'b1;
            state_d    = ST_IDLE;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = latch_pass | latch_fail;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign trial_valid = (state_q == ST_ISSUE);
  assign in_wait     = (state_q == ST_WAIT);
  assign busy        = (state_q != ST_IDLE);
  assign done        = done_q;

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

// File: rtl/addr_width_detect.sv
module addr_width_detect #(
  parameter int MAX_BITS = 12,
  parameter int MIN_BITS = 8,
  localparam int WW = $clog2(MAX_BITS + 1),
  localparam int AW = 2 * MAX_BITS,
  localparam int SW = MAX_BITS + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                trial_valid,
  input  logic                trial_ready,
  output logic [WW-1:0]       trial_width,
  output logic [AW-1:0]       trial_addr,
  output logic [MAX_BITS-1:0] trial_mask,
  input  logic                res_valid,
  input  logic                res_pass,
  output logic                busy,
  output logic                done,
  output logic                detect_fail,
  output logic [WW-1:0]       det_width,
  output logic [MAX_BITS-1:0] det_mask,
  output logic [SW-1:0]       mem_size
);
  localparam logic [WW-1:0] MIN_W  = WW'(MIN_BITS);
  localparam logic [WW-1:0] LAST_W = WW'(MIN_BITS + 1);

  logic [WW-1:0] cand;
  logic          load, dec, latch_pass, latch_fail, in_wait, cand_last;
  logic [SW-1:0] cand_size_unused;

  assign cand_last = (cand <= LAST_W);

  adw_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_ready(trial_ready),
    .res_valid(res_valid), .res_pass(res_pass), .cand_last(cand_last),
    .load(load), .dec(dec), .latch_pass(latch_pass), .latch_fail(latch_fail),
    .trial_valid(trial_valid), .busy(busy), .in_wait(in_wait), .done(done)
  );

  adw_cand #(.MAX_BITS(MAX_BITS), .WW(WW)) u_cand (
    .clk(clk), .rst_n(rst_n), .load(load), .dec(dec), .cand(cand)
  );

  adw_geom #(.MAX_BITS(MAX_BITS), .WW(WW)) u_geom_trial (
    .width(cand), .mask(trial_mask), .addr(trial_addr), .size(cand_size_unused)
  );

  // Result register
  logic [WW-1:0] width_d, width_q;
  logic          fail_d, fail_q, res_en;
  logic [AW-1:0] det_addr_unused;

  always_comb begin
    res_en  = latch_pass | latch_fail;
    width_d = width_q;
    fail_d  = fail_q;
    if (latch_pass) begin
      width_d = cand;
      fail_d  = 1'b0;
    end else if (latch_fail) begin
      width_d = MIN_W;
      fail_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= '0;
      fail_q  <= 1'b0;
    end else if (res_en) begin
      width_q <= width_d;
      fail_q  <= fail_d;
    end
  end

  adw_geom #(.MAX_BITS(MAX_BITS), .WW(WW)) u_geom_res (
    .width(width_q), .mask(det_mask), .addr(det_addr_unused), .size(mem_size)
  );

  assign trial_width = cand;
  assign det_width   = width_q;
  assign detect_fail = fail_q;

  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (trial_valid && !trial_ready) |=> (trial_valid && $stable(trial_width) && $stable(trial_addr)));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && res_valid && !res_pass && (trial_width > LAST_W))
      |=> (trial_valid && trial_width == $past(trial_width) - WW'(1)));
  a_r6_size: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_size == (SW'(1) << det_width)) && (32'(det_mask) == (32'(1) << det_width) - 1));
  a_r7_fail_width: assert property (@(posedge clk) disable iff (!rst_n)
    detect_fail |-> (det_width == MIN_W));
  a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !in_wait) |=> $stable(trial_width));
endmodule

// File: tb/test_addr_width_detect.sv
module test_addr_width_detect;
  logic        clk, rst_n, start, trial_ready, res_valid, res_pass;
  logic        trial_valid, busy, done, detect_fail;
  logic [3:0]  trial_width, det_width;
  logic [23:0] trial_addr;
  logic [11:0] trial_mask, det_mask;
  logic [12:0] mem_size;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  addr_width_detect i_addr_width_detect (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_valid(trial_valid),
    .trial_ready(trial_ready), .trial_width(trial_width), .trial_addr(trial_addr),
    .trial_mask(trial_mask), .res_valid(res_valid), .res_pass(res_pass),
    .busy(busy), .done(done), .detect_fail(detect_fail), .det_width(det_width),
    .det_mask(det_mask), .mem_size(mem_size)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic chk_results(input int w, input bit f, input string req);
    chk(det_width == 4'(w), req, det_width, w);
    chk(detect_fail == f, req, detect_fail, f);
    chk(det_mask == 12'((1 << w) - 1), "R6 mask", det_mask, (1 << w) - 1);
    chk(mem_size == 13'(1 << w), "R6 size", mem_size, 1 << w);
  endtask

  // One search against a module of depth k bits, latency rd, optional stray strobes.
  task automatic run_detect(input int k, input int rd, input bit poke);
    int exp_w, cur, ntr;
    bit exp_f, fin, pass;
    exp_w = (k >= 12) ? 12 : (k > 8 ? k : 8);
    exp_f = (k <= 8);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(busy == 1, "R2 busy", busy, 1);
    cur = 12; ntr = 0; fin = 0;
    while (!fin) begin
      chk(trial_valid == 1, "R4 trial offered", trial_valid, 1);
      chk(trial_width == 4'(cur), "R4 width", trial_width, cur);
      chk(trial_addr == 24'((longint'(1) << (2*cur)) - 1), "R4 addr", trial_addr,
          (longint'(1) << (2*cur)) - 1);
      chk(trial_mask == 12'((1 << cur) - 1), "R4 mask", trial_mask, (1 << cur) - 1);
      for (int d = 0; d < rd; d++) begin
        if (poke && d == 0) begin res_valid = 1; res_pass = 1; start = 1; end
        @(negedge clk);
        res_valid = 0; start = 0;
        chk(trial_valid == 1 && trial_width == 4'(cur), "R3/R9 hold", trial_width, cur);
      end
      trial_ready = 1;
      @(negedge clk); trial_ready = 0;
      chk(trial_valid == 0, "R3 accepted", trial_valid, 0);
      for (int d = 0; d < rd; d++) begin
        if (poke && d == 0) start = 1;
        @(negedge clk); start = 0;
        chk(busy == 1 && done == 0, "R8 start ignored", busy, 1);
      end
      pass = (cur <= k);
      res_valid = 1; res_pass = pass;
      if (poke) start = 1;
      @(negedge clk); res_valid = 0; res_pass = 0; start = 0;
      ntr++;
      if (pass || cur == 9) begin
        fin = 1;
        chk(done == 1 && busy == 0, "R5 done", {done, busy}, 2'b10);
        chk_results(exp_w, exp_f, exp_f ? "R7 fail result" : "R5 result");
        chk(ntr == (exp_f ? 4 : 13 - exp_w), exp_f ? "R7 trials" : "R5 trials", ntr,
            exp_f ? 4 : 13 - exp_w);
        @(negedge clk);
        chk(done == 0 && busy == 0, "R5/R8 one pulse, no restart", {done, busy}, 0);
      end else begin
        chk(done == 0 && trial_valid == 1, "R4 next trial", trial_valid, 1);
        cur--;
      end
    end
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected <20000", cyc);
        summary();
      end
    end
  end

  initial begin
    start = 0; trial_ready = 0; res_valid = 0; res_pass = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && trial_valid == 0, "R1 controls", {busy, done, trial_valid}, 0);
    chk_results(0, 0, "R1 results");
    // R9 response strobe while idle
    res_valid = 1; res_pass = 1;
    @(negedge clk); res_valid = 0; res_pass = 0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R9 idle response", {busy, done}, 0);
    chk_results(0, 0, "R9 idle results");
    for (int rd = 0; rd < 3; rd++)
      for (int k = 6; k <= 14; k++)
        run_detect(k, rd, rd == 2);
    summary();
  end
endmodule